// File: doc/BRIEF.md
# SDRAM Manual Command Sequencer

This block turns a four-bit manual command code from a host register interface into the control-pin activity an SDRAM rank expects. The host also supplies the index of the target chip select. The block drives the active-low chip selects, row strobe, column strobe and write enable, plus the clock enable. Some codes produce a single command cycle and some produce a timed sequence. The block raises busy while a command is running and pulses done when the command finishes.

The supported codes are:
- 0x0: a timed NOP hold, used for the power-up settling delay.
- 0x2: autorefresh.
- 0x3 and 0x4: entry into and exit from deep power-down.
- 0x5 and 0x6: entry into and exit from self-refresh.
- 0x7 and 0x8: forcing clock enable high or low.

Self-refresh exit is a compound sequence. Clock enable rises with a NOP, NOPs are held for the programmed exit window, and then one autorefresh is issued automatically. The host supplies both wait lengths as cycle counts. Codes that are not listed are refused, and the block reports the refusal with a one-cycle error flag.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, busy, done and cmd_err are low, every sd_cs_n line is high, sd_ras_n, sd_cas_n and sd_we_n are high, and sd_cke is low.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. For code 0x0, busy is high for max(pwrup_cycles,1) cycles starting the cycle after acceptance. During that time the pins show NOP (selected CS low, RAS/CAS/WE high) and sd_cke is unchanged.
- R3: Code 0x2 gives one busy cycle with selected CS low, RAS low, CAS low, WE high, and sd_cke driven high.
- R4: Code 0x3 gives one busy cycle with selected CS low, RAS high, CAS high, WE low, and sd_cke low. sd_cke stays low afterwards.
- R5: Code 0x4 gives one busy cycle with every chip select high and sd_cke driven high.
- R6: Code 0x5 gives one busy cycle with selected CS low, RAS low, CAS low, WE high, and sd_cke low.
- R7: Code 0x6 raises sd_cke. The pins then show NOP for max(txsr_cycles,1) cycles, followed by exactly one autorefresh cycle. Busy covers all of these cycles.
- R8: Code 0x7 sets sd_cke high and code 0x8 sets it low. In both cases the pins show only NOP during the single busy cycle.
- R9: Only the chip select whose index is cmd_cs is ever driven low, and at most one sd_cs_n line is low at any time.
- R10: done is high for exactly one cycle, namely the cycle right after the last busy cycle.
- R11: Codes 0x1 and 0x9 to 0xF are refused. They raise no busy and no done, and they leave the pins and the selected chip select unchanged. cmd_err is high for exactly the one cycle after the refused acceptance edge.
- R12: A command presented while busy is high is ignored and does not change the running sequence.
- R13: Between commands, the pins show NOP on the last selected chip select (all chip selects high if no command has yet been accepted), and sd_cke keeps its last commanded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host presents a command this cycle |
| cmd_code | input | 4 | Manual command code |
| cmd_cs | input | $clog2(NUM_CS) | Target chip select index |
| txsr_cycles | input | CNT_W | NOP cycles after self-refresh exit |
| pwrup_cycles | input | CNT_W | NOP hold length for code 0x0 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle refusal pulse for an unlisted code |
| sd_cs_n | output | NUM_CS | Active-low chip selects |
| sd_ras_n | output | 1 | Active-low row strobe |
| sd_cas_n | output | 1 | Active-low column strobe |
| sd_we_n | output | 1 | Active-low write enable |
| sd_cke | output | 1 | Clock enable |

## Verification
The pins are decoded directly from the state, the latched code and the chip-select mask. As a result, a wrong state or a mislatched code appears on the strobes or on sd_cke in the very first cycle after acceptance. A wrong countdown value does not show at once. It shows as the autorefresh, or the falling edge of busy, arriving one or more cycles early or late. The bench catches this because it compares every busy cycle of each sequence against a cycle-exact expected pattern. A stale chip-select mask shows up as the wrong line low during the idle NOP that follows the command.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic [CNT_W-1:0]  txsr_cycles,
  input  logic [CNT_W-1:0]  pwrup_cycles,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic [NUM_CS-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke
);

  localparam logic [3:0] C_NOP    = 4'h0;
  localparam logic [3:0] C_AREF   = 4'h2;
  localparam logic [3:0] C_DPD_IN = 4'h3;
  localparam logic [3:0] C_DPD_OUT= 4'h4;
  localparam logic [3:0] C_SR_IN  = 4'h5;
  localparam logic [3:0] C_SR_OUT = 4'h6;
  localparam logic [3:0] C_CKE_HI = 4'h7;
  localparam logic [3:0] C_CKE_LO = 4'h8;

  typedef enum logic [2:0] {S_IDLE, S_ONE, S_HOLD, S_XSR, S_AREF} st_t;

  st_t              st;
  logic [3:0]       op;
  logic [CNT_W-1:0] cnt;
  logic [NUM_CS-1:0] sel_n;
  logic             cke_q;
  logic             take, known, cnt_last;

  assign busy     = (st != S_IDLE);
  assign take     = cmd_valid && !busy;
  assign cnt_last = (cnt <= CNT_W'(1));

  always_comb begin
    case (cmd_code)
      C_NOP, C_AREF, C_DPD_IN, C_DPD_OUT,
      C_SR_IN, C_SR_OUT, C_CKE_HI, C_CKE_LO: known = 1'b1;
      default:                               known = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op      <= C_NOP;
      cnt     <= '0;
      sel_n   <= '1;
      cke_q   <= 1'b0;
      done    <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      cmd_err <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (!known) begin
            cmd_err <= 1'b1;
          end else begin
            op    <= cmd_code;
            sel_n <= ~({{(NUM_CS-1){1'b0}}, 1'b1} << cmd_cs);
            case (cmd_code)
              C_NOP: begin
                st  <= S_HOLD;
                cnt <= pwrup_cycles;
              end
              C_SR_OUT: begin
                st    <= S_XSR;
                cnt   <= txsr_cycles;
                cke_q <= 1'b1;
              end
              C_AREF, C_DPD_OUT, C_CKE_HI: begin
                st    <= S_ONE;
                cke_q <= 1'b1;
              end
              default: begin
                st    <= S_ONE;
                cke_q <= 1'b0;
              end
            endcase
          end
        end
        S_ONE: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        S_HOLD: begin
          if (cnt_last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_XSR: begin
          if (cnt_last) st <= S_AREF;
          else          cnt <= cnt - CNT_W'(1);
        end
        S_AREF: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic refresh_pat, dpd_pat;
  assign refresh_pat = (st == S_AREF) ||
                       (st == S_ONE && (op == C_AREF || op == C_SR_IN));
  assign dpd_pat     = (st == S_ONE) && (op == C_DPD_IN);

  assign sd_cs_n  = (st == S_ONE && op == C_DPD_OUT) ? '1 : sel_n;
  assign sd_ras_n = !refresh_pat;
  assign sd_cas_n = !refresh_pat;
  assign sd_we_n  = !dpd_pat;
  assign sd_cke   = cke_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cmd_err,
  input logic [NUM_CS-1:0] sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke
);

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sd_cs_n) <= 1); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (!busy && !done)); // R11

  AST_DPD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sd_ras_n && sd_cas_n && !sd_we_n) |-> !sd_cke); // R4

  AST_CKE_HELD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sd_cke)); // R12

  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_ras_n && sd_cas_n && sd_we_n)); // R13

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cmd_err(cmd_err),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_cke(sd_cke)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int NUM_CS = 4;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [1:0] cmd_cs = '0;
  logic [CNT_W-1:0] txsr_cycles = '0;
  logic [CNT_W-1:0] pwrup_cycles = '0;
  logic busy, done, cmd_err, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
  logic [NUM_CS-1:0] sd_cs_n;

  int total = 0;
  int bad = 0;
  logic [NUM_CS-1:0] m_sel = '1;
  logic m_cke = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_seq #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_cs(cmd_cs), .txsr_cycles(txsr_cycles), .pwrup_cycles(pwrup_cycles),
    .busy(busy), .done(done), .cmd_err(cmd_err), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_cke(sd_cke)
  );

  // {busy, done, err, cs_n[3:0], ras_n, cas_n, we_n, cke}
  function automatic logic [10:0] pack(input logic b, input logic d, input logic e,
                                       input logic [3:0] cs, input logic [2:0] rcw,
                                       input logic k);
    return {b, d, e, cs, rcw, k};
  endfunction

  function automatic bit is_known(input logic [3:0] c);
    return c == 4'h0 || (c >= 4'h2 && c <= 4'h8);
  endfunction

  task automatic chk(input string req, input logic [10:0] exp_v);
    logic [10:0] act;
    act = {busy, done, cmd_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp_v);
    end
  endtask

  task automatic run_cmd(input logic [3:0] code, input int cs, input int t,
                         input int p, input int inj_step);
    int len;
    string req;
    cmd_valid = 1'b1; cmd_code = code; cmd_cs = 2'(cs);
    txsr_cycles = CNT_W'(t); pwrup_cycles = CNT_W'(p);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!is_known(code)) begin
      chk("R11", pack(1'b0, 1'b0, 1'b1, m_sel, 3'b111, m_cke));
      @(negedge clk);
      chk("R11", pack(1'b0, 1'b0, 1'b0, m_sel, 3'b111, m_cke));
      return;
    end
    m_sel = ~(4'b0001 << cs);
    case (code)
      4'h2, 4'h4, 4'h6, 4'h7: m_cke = 1'b1;
      4'h3, 4'h5, 4'h8:       m_cke = 1'b0;
      default: ;
    endcase
    case (code)
      4'h0: len = (p < 1) ? 1 : p;
      4'h6: len = ((t < 1) ? 1 : t) + 1;
      default: len = 1;
    endcase
    case (code)
      4'h0: req = "R2";  4'h2: req = "R3";  4'h3: req = "R4";
      4'h4: req = "R5";  4'h5: req = "R6";  4'h6: req = "R7";
      default: req = "R8";
    endcase
    for (int s = 1; s <= len; s++) begin
      logic [3:0] ecs;
      logic [2:0] rcw;
      ecs = m_sel; rcw = 3'b111;
      case (code)
        4'h2, 4'h5: rcw = 3'b001;
        4'h3: rcw = 3'b110;
        4'h4: ecs = 4'hF;
        4'h6: if (s == len) rcw = 3'b001;
        default: ;
      endcase
      chk(s == inj_step + 1 && inj_step > 0 ? "R12" : req,
          pack(1'b1, 1'b0, 1'b0, ecs, rcw, m_cke));
      if (s == inj_step) begin
        cmd_valid = 1'b1; cmd_code = 4'h3; cmd_cs = 2'(cs + 1);
      end
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    chk("R10", pack(1'b0, 1'b1, 1'b0, m_sel, 3'b111, m_cke));
    @(negedge clk);
    chk("R13", pack(1'b0, 1'b0, 1'b0, m_sel, 3'b111, m_cke));
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", pack(1'b0, 1'b0, 1'b0, 4'hF, 3'b111, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pack(1'b0, 1'b0, 1'b0, 4'hF, 3'b111, 1'b0));

    run_cmd(4'h9, 1, 0, 0, 0);     // R11 before any selection
    run_cmd(4'h0, 2, 0, 0, 0);     // R2 zero count
    run_cmd(4'h0, 1, 0, 5, 0);     // R2
    run_cmd(4'h7, 0, 0, 0, 0);     // R8
    run_cmd(4'h2, 3, 0, 0, 0);     // R3, R9
    run_cmd(4'h5, 2, 0, 0, 0);     // R6
    run_cmd(4'h6, 2, 0, 0, 0);     // R7 zero window
    run_cmd(4'h6, 1, 6, 0, 3);     // R7, R12 reject mid-sequence
    run_cmd(4'h3, 0, 0, 0, 0);     // R4
    run_cmd(4'h4, 0, 0, 0, 1);     // R5, R12
    run_cmd(4'h8, 3, 0, 0, 0);     // R8
    run_cmd(4'h1, 2, 0, 0, 0);     // R11
    run_cmd(4'hF, 0, 0, 0, 0);     // R11

    for (int i = 0; i < 400; i++) begin
      int gap;
      run_cmd(4'($urandom % 16), int'($urandom % 4), int'($urandom % 5),
              int'($urandom % 5), int'($urandom % 3));
      gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R13", pack(1'b0, 1'b0, 1'b0, m_sel, 3'b111, m_cke));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule